// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block sits beside the decode stage of a hart that supports supervisor and hypervisor execution. For each privileged instruction it is shown (wait-for-interrupt, the supervisor address-translation fence, and the two hypervisor fences for guest virtual and guest physical translations), it decides whether the instruction may run. It works from the current privilege level, the virtualization flag, the machine-level trap bits for wait and virtual memory, the matching guest-level trap bits, and two straps that say whether supervisor mode and the hypervisor are present.

The verdict is combinational: exactly one of grant, illegal-instruction or virtual-instruction fault is raised while the instruction is valid, with a trap cause code beside it. A granted wait-for-interrupt produces a one-cycle halt request on the following clock; a granted fence produces a one-cycle translation-flush pulse on the following clock. The wake-up logic and the translation cache are outside the block.

Top module: `priv_insn_gate`

## Requirements
- R1: A wait-for-interrupt (op code 0) is illegal when the wait-trap bit is set and the privilege is supervisor (code 1), or user (code 0) on a hart whose supervisor strap is low.
- R2: With the supervisor strap high, a wait-for-interrupt from user mode while virtualization is off is illegal whatever the trap bits hold.
- R3: A wait-for-interrupt that is not illegal raises a virtual-instruction fault when virtualization is on and the privilege is user, or supervisor with the guest wait-trap bit set.
- R4: A wait-for-interrupt that is granted drives halt_req high for exactly the one cycle after the clock edge that samples it.
- R5: A supervisor fence (op code 1) is illegal from user mode, and from supervisor mode while the virtual-memory trap bit is set; machine mode is code 3.
- R6: A supervisor fence that is not illegal raises a virtual-instruction fault when the hypervisor strap, virtualization and the guest virtual-memory trap bit are all high; otherwise it is granted and tlb_flush pulses for one cycle after the sampling edge.
- R7: A guest-virtual fence (op code 2) raises a virtual-instruction fault in supervisor mode with virtualization on, is granted in machine mode or in supervisor mode with virtualization off, and is illegal in every other case.
- R8: A guest-physical fence (op code 3) is illegal in supervisor mode with virtualization off while the virtual-memory trap bit is set; otherwise it follows R7.
- R9: While insn_valid is high exactly one of grant, raise_illegal and raise_virtual is high, trap_cause reads 2 for illegal-instruction and 22 for virtual-instruction fault and 0 on grant; while insn_valid is low all three and trap_cause are zero.
- R10: The reserved privilege code 2 makes every instruction illegal.
- R11: halt_req and tlb_flush are low during reset, never high together, and stay low after a cycle whose instruction was invalid or not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_valid | input | 1 | A privileged instruction is presented this cycle |
| insn_op | input | 2 | 0 wait, 1 supervisor fence, 2 guest-virtual fence, 3 guest-physical fence |
| cur_priv | input | 2 | 0 user, 1 supervisor, 2 reserved, 3 machine |
| virt_on | input | 1 | Hart runs a guest (virtualization on) |
| trap_wfi | input | 1 | Machine-level wait-trap bit |
| trap_vm | input | 1 | Machine-level virtual-memory trap bit |
| guest_trap_wfi | input | 1 | Hypervisor-level wait-trap bit for guests |
| guest_trap_vm | input | 1 | Hypervisor-level virtual-memory trap bit for guests |
| has_smode | input | 1 | Strap: supervisor mode present |
| has_hyp | input | 1 | Strap: hypervisor present |
| grant | output | 1 | Instruction may execute |
| raise_illegal | output | 1 | Illegal-instruction exception |
| raise_virtual | output | 1 | Virtual-instruction fault |
| trap_cause | output | CAUSE_W | Cause code of the raised trap |
| halt_req | output | 1 | One-cycle halt request after a granted wait |
| tlb_flush | output | 1 | One-cycle flush pulse after a granted fence |

## Verification
The registered halt or flush pulse of one instruction lands in the same cycle as the combinational verdict of the next, so the bench presents instructions back to back with no idle gap, including a granted wait followed at once by a granted fence and the reverse. Each cycle the pulses are judged against the expectation saved from the previous instruction while the verdict and cause are judged against the current one, so a pulse leaking from the wrong instruction or a verdict that lags by a cycle is caught.

// File: rtl/priv_insn_gate_pkg.sv
package priv_insn_gate_pkg;

   typedef enum logic [1:0] {
      PRV_USER  = 2'd0,
      PRV_SUPER = 2'd1,
      PRV_RSVD  = 2'd2,
      PRV_MACH  = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      OP_WFI    = 2'd0,
      OP_SFENCE = 2'd1,
      OP_HFV    = 2'd2,
      OP_HFG    = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      VD_ALLOW   = 2'd0,
      VD_ILLEGAL = 2'd1,
      VD_VFAULT  = 2'd2
   } verdict_e;

   localparam int FK_SUPER  = 0;
   localparam int FK_GUEST  = 1;
   localparam int FK_GSTAGE = 2;
   localparam int NUM_FENCE_KINDS = 3;

endpackage

// File: rtl/pig_wfi_rule.sv
module pig_wfi_rule
   import priv_insn_gate_pkg::*;
(
   input  priv_e    priv,
   input  logic     virt,
   input  logic     tw,
   input  logic     vtw,
   input  logic     has_s,
   output verdict_e verdict
);

   logic is_u;
   logic is_s;
   logic hit_illegal;
   logic hit_virtual;

   always_comb begin
      is_u        = (priv == PRV_USER);
      is_s        = (priv == PRV_SUPER);
      hit_illegal = ((is_s || (!has_s && is_u)) && tw) || (has_s && is_u && !virt);
      hit_virtual = virt && (is_u || (is_s && vtw));
      if (hit_illegal)      verdict = VD_ILLEGAL;
      else if (hit_virtual) verdict = VD_VFAULT;
      else                  verdict = VD_ALLOW;
   end

endmodule

// File: rtl/pig_fence_rule.sv
module pig_fence_rule
   import priv_insn_gate_pkg::*;
#(
   parameter int KIND = FK_SUPER
) (
   input  priv_e    priv,
   input  logic     virt,
   input  logic     tvm,
   input  logic     vtvm,
   input  logic     has_h,
   output verdict_e verdict
);

   if (KIND < 0 || KIND >= NUM_FENCE_KINDS) begin : g_bad_kind
      $error("pig_fence_rule: KIND out of range");
   end

   logic is_u;
   logic is_s;
   logic is_m;
   assign is_u = (priv == PRV_USER);
   assign is_s = (priv == PRV_SUPER);
   assign is_m = (priv == PRV_MACH);

   if (KIND == FK_SUPER) begin : g_super
      logic unused_sup;
      assign unused_sup = is_m;
      always_comb begin
         if (is_u || (is_s && tvm))       verdict = VD_ILLEGAL;
         else if (has_h && virt && vtvm)  verdict = VD_VFAULT;
         else                             verdict = VD_ALLOW;
      end
   end else begin : g_hyp
      logic gstage_block;
      logic unused_hyp;
      assign unused_hyp   = ^{vtvm, has_h, is_u};
      assign gstage_block = (KIND == FK_GSTAGE) && is_s && !virt && tvm;
      always_comb begin
         if (gstage_block)                verdict = VD_ILLEGAL;
         else if (is_s && virt)           verdict = VD_VFAULT;
         else if (is_m || (is_s && !virt)) verdict = VD_ALLOW;
         else                             verdict = VD_ILLEGAL;
      end
   end

endmodule

// File: rtl/pig_outcome.sv
module pig_outcome
   import priv_insn_gate_pkg::*;
#(
   parameter int CAUSE_W    = 5,
   parameter int ILL_CAUSE  = 2,
   parameter int VIRT_CAUSE = 22
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  op_e                op,
   input  logic               priv_rsvd,
   input  verdict_e           vd_wfi,
   input  verdict_e           vd_sfence,
   input  verdict_e           vd_hfv,
   input  verdict_e           vd_hfg,
   output logic               grant,
   output logic               raise_ill,
   output logic               raise_virt,
   output logic [CAUSE_W-1:0] cause,
   output logic               halt_req,
   output logic               tlb_flush
);

   localparam int CAUSE_LIMIT = 1 << CAUSE_W;

   if (CAUSE_W < 1 || CAUSE_W > 16) begin : g_bad_width
      $error("pig_outcome: CAUSE_W must be 1..16");
   end
   if (ILL_CAUSE >= CAUSE_LIMIT || VIRT_CAUSE >= CAUSE_LIMIT) begin : g_bad_cause
      $error("pig_outcome: cause code does not fit CAUSE_W");
   end
   if (ILL_CAUSE == VIRT_CAUSE || ILL_CAUSE == 0 || VIRT_CAUSE == 0) begin : g_bad_codes
      $error("pig_outcome: cause codes must be distinct and nonzero");
   end

   verdict_e chosen;
   logic     is_wfi;

   always_comb begin
      unique case (op)
         OP_WFI:    chosen = vd_wfi;
         OP_SFENCE: chosen = vd_sfence;
         OP_HFV:    chosen = vd_hfv;
         default:   chosen = vd_hfg;
      endcase
      if (priv_rsvd) chosen = VD_ILLEGAL;
   end

   assign is_wfi     = (op == OP_WFI);
   assign grant      = valid && (chosen == VD_ALLOW);
   assign raise_ill  = valid && (chosen == VD_ILLEGAL);
   assign raise_virt = valid && (chosen == VD_VFAULT);

   always_comb begin
      if (raise_ill)       cause = CAUSE_W'(ILL_CAUSE);
      else if (raise_virt) cause = CAUSE_W'(VIRT_CAUSE);
      else                 cause = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_req  <= 1'b0;
         tlb_flush <= 1'b0;
      end else begin
         halt_req  <= grant && is_wfi;
         tlb_flush <= grant && !is_wfi;
      end
   end

   p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $countones({grant, raise_ill, raise_virt}) == 1);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (!grant && !raise_ill && !raise_virt && cause == '0));
   p_cause_ill_r9: assert property (@(posedge clk) disable iff (!rst_n)
      raise_ill |-> cause == CAUSE_W'(ILL_CAUSE));
   p_cause_virt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      raise_virt |-> cause == CAUSE_W'(VIRT_CAUSE));
   p_halt_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && is_wfi) |=> halt_req);
   p_flush_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !is_wfi) |=> tlb_flush);
   p_pulse_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_req && tlb_flush));
   p_pulse_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid && grant) |=> (!halt_req && !tlb_flush));

endmodule

// File: rtl/priv_insn_gate.sv
module priv_insn_gate
   import priv_insn_gate_pkg::*;
#(
   parameter int CAUSE_W    = 5,
   parameter int ILL_CAUSE  = 2,
   parameter int VIRT_CAUSE = 22
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               insn_valid,
   input  logic [1:0]         insn_op,
   input  logic [1:0]         cur_priv,
   input  logic               virt_on,
   input  logic               trap_wfi,
   input  logic               trap_vm,
   input  logic               guest_trap_wfi,
   input  logic               guest_trap_vm,
   input  logic               has_smode,
   input  logic               has_hyp,
   output logic               grant,
   output logic               raise_illegal,
   output logic               raise_virtual,
   output logic [CAUSE_W-1:0] trap_cause,
   output logic               halt_req,
   output logic               tlb_flush
);

   priv_e    priv;
   op_e      op;
   verdict_e vd_wfi;
   verdict_e vd_fence [NUM_FENCE_KINDS];

   assign priv = priv_e'(cur_priv);
   assign op   = op_e'(insn_op);

   pig_wfi_rule u_wfi (
      .priv    (priv),
      .virt    (virt_on),
      .tw      (trap_wfi),
      .vtw     (guest_trap_wfi),
      .has_s   (has_smode),
      .verdict (vd_wfi)
   );

   for (genvar k = 0; k < NUM_FENCE_KINDS; k++) begin : g_fence
      pig_fence_rule #(.KIND(k)) u_rule (
         .priv    (priv),
         .virt    (virt_on),
         .tvm     (trap_vm),
         .vtvm    (guest_trap_vm),
         .has_h   (has_hyp),
         .verdict (vd_fence[k])
      );
   end

   pig_outcome #(
      .CAUSE_W    (CAUSE_W),
      .ILL_CAUSE  (ILL_CAUSE),
      .VIRT_CAUSE (VIRT_CAUSE)
   ) u_outcome (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (insn_valid),
      .op         (op),
      .priv_rsvd  (priv == PRV_RSVD),
      .vd_wfi     (vd_wfi),
      .vd_sfence  (vd_fence[FK_SUPER]),
      .vd_hfv     (vd_fence[FK_GUEST]),
      .vd_hfg     (vd_fence[FK_GSTAGE]),
      .grant      (grant),
      .raise_ill  (raise_illegal),
      .raise_virt (raise_virtual),
      .cause      (trap_cause),
      .halt_req   (halt_req),
      .tlb_flush  (tlb_flush)
   );

   p_wfi_tw_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_op == 2'd0 && trap_wfi && cur_priv == 2'd1) |-> raise_illegal);
   p_wfi_user_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_op == 2'd0 && cur_priv == 2'd0 && has_smode && !virt_on) |-> raise_illegal);
   p_wfi_guest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_op == 2'd0 && cur_priv == 2'd0 && virt_on && !trap_wfi) |-> raise_virtual);
   p_sfence_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_op == 2'd1 && cur_priv == 2'd0) |-> raise_illegal);
   p_hfv_guest_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_op == 2'd2 && cur_priv == 2'd1 && virt_on) |-> raise_virtual);
   p_hfg_tvm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && insn_op == 2'd3 && cur_priv == 2'd1 && !virt_on && trap_vm) |-> raise_illegal);
   p_rsvd_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_valid && cur_priv == 2'd2) |-> raise_illegal);

endmodule

// File: tb/priv_insn_gate_bench.sv
`timescale 1ns/1ps
module priv_insn_gate_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       insn_valid = 1'b0;
   logic [1:0] insn_op = 2'd0;
   logic [1:0] cur_priv = 2'd3;
   logic       virt_on = 1'b0;
   logic       trap_wfi = 1'b0;
   logic       trap_vm = 1'b0;
   logic       guest_trap_wfi = 1'b0;
   logic       guest_trap_vm = 1'b0;
   logic       has_smode = 1'b1;
   logic       has_hyp = 1'b1;
   logic       grant;
   logic       raise_illegal;
   logic       raise_virtual;
   logic [4:0] trap_cause;
   logic       halt_req;
   logic       tlb_flush;

   int checks = 0;
   int failures = 0;
   bit exp_halt = 1'b0;
   bit exp_flush = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   priv_insn_gate u_priv_insn_gate (
      .clk            (clk),
      .rst_n          (rst_n),
      .insn_valid     (insn_valid),
      .insn_op        (insn_op),
      .cur_priv       (cur_priv),
      .virt_on        (virt_on),
      .trap_wfi       (trap_wfi),
      .trap_vm        (trap_vm),
      .guest_trap_wfi (guest_trap_wfi),
      .guest_trap_vm  (guest_trap_vm),
      .has_smode      (has_smode),
      .has_hyp        (has_hyp),
      .grant          (grant),
      .raise_illegal  (raise_illegal),
      .raise_virtual  (raise_virtual),
      .trap_cause     (trap_cause),
      .halt_req       (halt_req),
      .tlb_flush      (tlb_flush)
   );

   // outcome codes: 0 none, 1 grant, 2 illegal, 3 virtual fault
   function automatic int model(bit v, int op, int pr, bit vi, bit tw, bit tvm,
                                bit vtw, bit vtvm, bit hs, bit hh);
      bit u = (pr == 0);
      bit s = (pr == 1);
      bit m = (pr == 3);
      if (!v) return 0;
      if (pr == 2) return 2;
      case (op)
         0: begin
            if (((s || (!hs && u)) && tw) || (hs && u && !vi)) return 2;
            if (vi && (u || (s && vtw))) return 3;
            return 1;
         end
         1: begin
            if (u || (s && tvm)) return 2;
            if (hh && vi && vtvm) return 3;
            return 1;
         end
         default: begin
            if (op == 3 && s && !vi && tvm) return 2;
            if (s && vi) return 3;
            if (m || (s && !vi)) return 1;
            return 2;
         end
      endcase
   endfunction

   function automatic string tag_for(bit v, int op, int pr, int code, bit u_nov_hs);
      if (!v) return "R9";
      if (pr == 2) return "R10";
      case (op)
         0: return (code == 1) ? "R4" : (code == 3) ? "R3" : (u_nov_hs ? "R2" : "R1");
         1: return (code == 2) ? "R5" : "R6";
         2: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic apply(bit v, int op, int pr, bit vi, bit tw, bit tvm, bit vtw,
                        bit vtvm, bit hs, bit hh, string tag_in);
      int code;
      int want_cause;
      string tag;
      @(negedge clk);
      check(exp_halt ? "R4" : "R11", "halt_req", int'(halt_req), int'(exp_halt));
      check(exp_flush ? "R6" : "R11", "tlb_flush", int'(tlb_flush), int'(exp_flush));
      insn_valid = v; insn_op = 2'(op); cur_priv = 2'(pr); virt_on = vi;
      trap_wfi = tw; trap_vm = tvm; guest_trap_wfi = vtw; guest_trap_vm = vtvm;
      has_smode = hs; has_hyp = hh;
      #1;
      code = model(v, op, pr, vi, tw, tvm, vtw, vtvm, hs, hh);
      tag = (tag_in == "") ? tag_for(v, op, pr, code, hs && pr == 0 && !vi) : tag_in;
      want_cause = (code == 2) ? 2 : (code == 3) ? 22 : 0;
      check(tag, "grant", int'(grant), int'(code == 1));
      check(tag, "raise_illegal", int'(raise_illegal), int'(code == 2));
      check(tag, "raise_virtual", int'(raise_virtual), int'(code == 3));
      check("R9", "trap_cause", int'(trap_cause), want_cause);
      exp_halt  = (code == 1) && (op == 0);
      exp_flush = (code == 1) && (op != 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R11", "halt_req in reset", int'(halt_req), 0);
      check("R11", "tlb_flush in reset", int'(tlb_flush), 0);
      check("R9", "grant idle", int'(grant), 0);
      check("R9", "cause idle", int'(trap_cause), 0);
      rst_n = 1'b1;

      //     v op pr vi tw tvm vtw vtvm hs hh
      apply(1, 0, 1, 0, 1, 0, 0, 0, 1, 1, "R1");  // S-mode wait with trap bit
      apply(1, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R1");  // U-mode, no S strap, trap bit
      apply(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");  // U-mode, no S strap, no trap: granted
      apply(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R2");  // U-mode with S strap, no virt
      apply(1, 0, 0, 1, 0, 0, 0, 0, 1, 1, "R3");  // guest user
      apply(1, 0, 1, 1, 0, 0, 1, 0, 1, 1, "R3");  // guest supervisor with guest trap
      apply(1, 0, 1, 1, 0, 0, 0, 0, 1, 1, "R4");  // guest supervisor, granted
      apply(1, 1, 3, 0, 0, 1, 0, 0, 1, 1, "R6");  // back to back: flush after halt
      apply(1, 0, 3, 0, 1, 0, 0, 0, 1, 1, "R4");  // machine wait ignores trap bit
      apply(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, "R5");
      apply(1, 1, 1, 0, 0, 1, 0, 0, 1, 1, "R5");
      apply(1, 1, 1, 1, 0, 0, 0, 1, 1, 1, "R6");  // guest vm trap: virtual fault
      apply(1, 1, 1, 1, 0, 0, 0, 1, 1, 0, "R6");  // same without hypervisor: grant
      apply(1, 2, 1, 1, 0, 0, 0, 0, 1, 1, "R7");
      apply(1, 2, 1, 0, 0, 1, 0, 0, 1, 1, "R7");  // guest-virtual ignores trap_vm
      apply(1, 2, 0, 0, 0, 0, 0, 0, 1, 1, "R7");
      apply(1, 2, 0, 1, 0, 0, 0, 0, 1, 1, "R7");
      apply(1, 3, 1, 0, 0, 1, 0, 0, 1, 1, "R8");
      apply(1, 3, 1, 1, 0, 1, 0, 0, 1, 1, "R8");
      apply(1, 3, 3, 0, 0, 1, 0, 0, 1, 1, "R8");
      apply(1, 0, 2, 0, 0, 0, 0, 0, 1, 1, "R10");
      apply(1, 2, 2, 0, 0, 0, 0, 0, 1, 1, "R10");
      apply(0, 1, 3, 0, 0, 0, 0, 0, 1, 1, "R9");  // invalid: no verdict, no pulse
      apply(0, 0, 3, 0, 0, 0, 0, 0, 1, 1, "R11");

      begin
         int unsigned seed = 32'h5eed_1234;
         void'($urandom(seed));
      end
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom;
         apply(($urandom % 8) != 0, $urandom % 4, $urandom % 4, r[0], r[1], r[2],
               r[3], r[4], r[5], r[6], "");
      end
      apply(0, 0, 3, 0, 0, 0, 0, 0, 1, 1, "R11");
      @(negedge clk);
      check("R11", "halt_req final", int'(halt_req), 0);
      check("R11", "tlb_flush final", int'(tlb_flush), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule